// File: doc/BRIEF.md
# System Exception Control Register Block

This block keeps the software-visible state for a core's fixed system exceptions: the non-maskable interrupt, the deferred service request, the periodic tick, the memory, bus and usage faults, the supervisor call and debug. It also keeps one pending bit for each external interrupt line. Software reaches it through a simple word-wide register port. It can set and clear pending state, read packed status words, program the vector table base and issue keyed reset-control requests. It can also trigger any external line by its number.

An external prioritiser decides what to take next. It reads the pending and enable vectors from this block. In return it supplies the vector currently being handled, a flag saying whether another handler sits preempted beneath it, a per-vector active mask, and the highest pending vector. When the prioritiser accepts a vector, it reports that with an acknowledge strobe, and the block drops that vector's pending bit. Hardware sources raise system pending bits through a raise strobe. External lines raise their pending bits on a rising edge.

Exception vector numbers follow a fixed map. Vectors 0 to 15 are system exceptions: the non-maskable interrupt is vector 2, memory fault 4, bus fault 5, usage fault 6, supervisor call 11, debug 12, deferred service 14 and the tick 15. External line n is vector 16+n.

Top module: `sysexc_regs`

## Requirements
- R1: After synchronous reset, every pending bit, the fault enables, the vector base, the request pulses and `rdata` are zero. `sys_en` then equals 0xD804, which has the fault vectors 4, 5 and 6 disabled.
- R2: In a write to the control/state word at 0xD04, bit 31 sets the non-maskable pending bit (vector 2). Bit 28 sets the deferred service pending bit (vector 14), and bit 27 clears it. Bit 26 sets the tick pending bit (vector 15), and bit 25 clears it. When the set bit and the clear bit are both written, the set bit wins.
- R3: A read of 0xD04 returns a packed word. Bits 8:0 hold the active vector, or 0 if none is active. Bit 11 is 1 when no vector is active or nothing is preempted. Bits 20:12 hold the highest pending vector, or 0 if none. Bit 22 is 1 when any external line is pending. Bit 26 reports tick pending, bit 28 deferred service pending and bit 31 non-maskable pending. All other bits read 0.
- R4: At 0xD24, active state is reported on bits 0, 1, 3, 7, 8, 10 and 11, for vectors 4, 5, 6, 11, 12, 14 and 15 in that order. Pending state is reported on bits 12 to 15, for vectors 6, 4, 5 and 11 in that order. Bits 18:16 are writable enables for vectors 4, 5 and 6, and they gate the matching `sys_en` bits.
- R5: A write to 0xD08 stores the word with bits 6:0 forced to zero. The stored value appears on `vec_base` and is returned by reads of 0xD08.
- R6: A write to 0xD0C acts only when bits 31:16 equal 0x05FA. In that case, bit 2 produces a one-cycle `rst_req` pulse and bit 1 a one-cycle `vclr_req` pulse. Writes without the key produce no pulse. Reads of 0xD0C return 0xFA050000.
- R7: A write to 0xF00 sets the pending bit of the external line numbered by bits 8:0. If that number is not below NIRQ, the write is ignored.
- R8: A read of 0x004 returns NIRQ/32 − 1.
- R9: A rising edge on `irq_in[n]` sets external pending bit n. A line that stays high does not set the bit again after the bit is cleared.
- R10: An acknowledge of vector v clears v's pending bit. If a set for the same vector arrives in the same cycle, the bit stays set.
- R11: Unmapped offsets read as zero, and writes to them change no state.
- R12: `rdata` is loaded one cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_in | input | NIRQ | External interrupt lines |
| sys_raise | input | 16 | Hardware raise strobes for system vectors 0–15 |
| ack_valid | input | 1 | Prioritiser accepted a vector |
| ack_vec | input | 9 | Accepted vector number |
| act_valid | input | 1 | A handler is currently active |
| act_vec | input | 9 | Currently active vector |
| nested | input | 1 | Another handler is preempted beneath the active one |
| sys_active | input | 16 | Per-vector active mask for system vectors |
| hp_valid | input | 1 | A pending vector is known |
| hp_vec | input | 9 | Highest pending vector |
| sys_pend | output | 16 | System pending bits by vector number |
| ext_pend | output | NIRQ | External pending bits by line |
| sys_en | output | 16 | System enables by vector number |
| vec_base | output | 32 | Vector table base |
| rst_req | output | 1 | Keyed system reset request pulse |
| vclr_req | output | 1 | Keyed clear-active request pulse |

## Verification
A pending bit can be set and acknowledged in the same cycle. The set may come from a control/state write, from a rising edge on a line, or from a trigger write. The bench provokes this by driving the acknowledge strobe in the same cycle as the set: first for the non-maskable vector together with a bit-31 write, then for an external line whose input rises in that cycle. It expects the bit to stay set in both cases. Acknowledges made alone are checked to clear the bit. The bench also writes a set and a clear for the same exception in one word, and reads the bit back to confirm that the set wins.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    localparam int VEC_W  = 9;
    localparam int ADDR_W = 12;
    localparam int SYS_N  = 16;

    localparam int V_NMI   = 2;
    localparam int V_MEM   = 4;
    localparam int V_BUS   = 5;
    localparam int V_USAGE = 6;
    localparam int V_SVC   = 11;
    localparam int V_DEBUG = 12;
    localparam int V_DSR   = 14;
    localparam int V_TICK  = 15;

    localparam logic [SYS_N-1:0] SYS_IMPL =
        SYS_N'((1 << V_NMI) | (1 << V_MEM) | (1 << V_BUS) | (1 << V_USAGE) |
               (1 << V_SVC) | (1 << V_DEBUG) | (1 << V_DSR) | (1 << V_TICK));

    localparam logic [ADDR_W-1:0] OFF_LINES = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CTLST = 12'hD04;
    localparam logic [ADDR_W-1:0] OFF_VBASE = 12'hD08;
    localparam logic [ADDR_W-1:0] OFF_RSTC  = 12'hD0C;
    localparam logic [ADDR_W-1:0] OFF_HSTAT = 12'hD24;
    localparam logic [ADDR_W-1:0] OFF_TRIG  = 12'hF00;

    localparam logic [15:0] RST_WR_KEY = 16'h05FA;
    localparam logic [15:0] RST_RD_KEY = 16'hFA05;

    typedef struct packed {
        logic lines;
        logic ctlst;
        logic vbase;
        logic rstc;
        logic hstat;
        logic trig;
    } sel_t;

    typedef struct packed {
        logic nmi_set;
        logic dsr_set;
        logic dsr_clr;
        logic tick_set;
        logic tick_clr;
    } ctl_cmd_t;

    function automatic sel_t decode(input logic [ADDR_W-1:0] a);
        sel_t s;
        s.lines = (a == OFF_LINES);
        s.ctlst = (a == OFF_CTLST);
        s.vbase = (a == OFF_VBASE);
        s.rstc  = (a == OFF_RSTC);
        s.hstat = (a == OFF_HSTAT);
        s.trig  = (a == OFF_TRIG);
        return s;
    endfunction

endpackage

// File: rtl/sysexc_sys.sv
module sysexc_sys
    import sysexc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  ctl_cmd_t                cmd,
    input  logic                    fen_we,
    input  logic [2:0]              fen_wd,
    input  logic [SYS_N-1:0]        raise,
    input  logic                    ack_valid,
    input  logic [VEC_W-1:0]        ack_vec,
    output logic [SYS_N-1:0]        pend,
    output logic [2:0]              fen,
    output logic [SYS_N-1:0]        en
);

    logic [SYS_N-1:0] set_v;
    logic [SYS_N-1:0] clr_v;

    always_comb begin
        set_v = raise;
        set_v[V_NMI]  = set_v[V_NMI]  | cmd.nmi_set;
        set_v[V_DSR]  = set_v[V_DSR]  | cmd.dsr_set;
        set_v[V_TICK] = set_v[V_TICK] | cmd.tick_set;
        clr_v = '0;
        clr_v[V_DSR]  = cmd.dsr_clr;
        clr_v[V_TICK] = cmd.tick_clr;
        for (int i = 0; i < SYS_N; i++) begin
            if (ack_valid && ack_vec == VEC_W'(i)) clr_v[i] = 1'b1;
        end
    end

    // set wins over clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            fen  <= '0;
        end else begin
            pend <= (set_v | (pend & ~clr_v)) & SYS_IMPL;
            if (fen_we) fen <= fen_wd;
        end
    end

    always_comb begin
        en = SYS_IMPL;
        en[V_MEM]   = fen[0];
        en[V_BUS]   = fen[1];
        en[V_USAGE] = fen[2];
    end

endmodule

// File: rtl/sysexc_ext.sv
module sysexc_ext
    import sysexc_pkg::*;
#(
    parameter int NIRQ = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NIRQ-1:0]     irq_in,
    input  logic                trig_we,
    input  logic [VEC_W-1:0]    trig_idx,
    input  logic                ack_valid,
    input  logic [VEC_W-1:0]    ack_vec,
    output logic [NIRQ-1:0]     pend
);

    logic [NIRQ-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_in;
    end

    for (genvar g = 0; g < NIRQ; g++) begin : g_line
        logic set_l;
        logic clr_l;
        assign set_l = (irq_in[g] & ~prev_q[g]) |
                       (trig_we && trig_idx == VEC_W'(g));
        assign clr_l = ack_valid && ack_vec == VEC_W'(SYS_N + g);
        always_ff @(posedge clk) begin
            if (rst)        pend[g] <= 1'b0;
            else if (set_l) pend[g] <= 1'b1;
            else if (clr_l) pend[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/sysexc_rdmux.sv
module sysexc_rdmux
    import sysexc_pkg::*;
#(
    parameter int NIRQ = 64
) (
    input  sel_t                sel,
    input  logic [SYS_N-1:0]    sys_pend,
    input  logic [NIRQ-1:0]     ext_pend,
    input  logic [2:0]          fen,
    input  logic [SYS_N-1:0]    sys_active,
    input  logic                act_valid,
    input  logic [VEC_W-1:0]    act_vec,
    input  logic                nested,
    input  logic                hp_valid,
    input  logic [VEC_W-1:0]    hp_vec,
    input  logic [31:0]         vec_base,
    output logic [31:0]         word
);

    localparam logic [31:0] LINES_VAL = 32'(NIRQ / 32 - 1);

    logic [31:0] ctl_word;
    logic [31:0] hs_word;

    always_comb begin
        ctl_word        = '0;
        ctl_word[8:0]   = act_valid ? act_vec : '0;
        ctl_word[11]    = !act_valid || !nested;
        ctl_word[20:12] = hp_valid ? hp_vec : '0;
        ctl_word[22]    = |ext_pend;
        ctl_word[26]    = sys_pend[V_TICK];
        ctl_word[28]    = sys_pend[V_DSR];
        ctl_word[31]    = sys_pend[V_NMI];
    end

    always_comb begin
        hs_word        = '0;
        hs_word[0]     = sys_active[V_MEM];
        hs_word[1]     = sys_active[V_BUS];
        hs_word[3]     = sys_active[V_USAGE];
        hs_word[7]     = sys_active[V_SVC];
        hs_word[8]     = sys_active[V_DEBUG];
        hs_word[10]    = sys_active[V_DSR];
        hs_word[11]    = sys_active[V_TICK];
        hs_word[12]    = sys_pend[V_USAGE];
        hs_word[13]    = sys_pend[V_MEM];
        hs_word[14]    = sys_pend[V_BUS];
        hs_word[15]    = sys_pend[V_SVC];
        hs_word[18:16] = fen;
    end

    always_comb begin
        unique case (1'b1)
            sel.lines: word = LINES_VAL;
            sel.ctlst: word = ctl_word;
            sel.vbase: word = vec_base;
            sel.rstc:  word = {RST_RD_KEY, 16'h0000};
            sel.hstat: word = hs_word;
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/sysexc_regs.sv
module sysexc_regs
    import sysexc_pkg::*;
#(
    parameter int NIRQ = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [11:0]         addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NIRQ-1:0]     irq_in,
    input  logic [15:0]         sys_raise,
    input  logic                ack_valid,
    input  logic [8:0]          ack_vec,
    input  logic                act_valid,
    input  logic [8:0]          act_vec,
    input  logic                nested,
    input  logic [15:0]         sys_active,
    input  logic                hp_valid,
    input  logic [8:0]          hp_vec,
    output logic [15:0]         sys_pend,
    output logic [NIRQ-1:0]     ext_pend,
    output logic [15:0]         sys_en,
    output logic [31:0]         vec_base,
    output logic                rst_req,
    output logic                vclr_req
);

    localparam logic [31:0] VBASE_MASK = 32'hFFFF_FF80;

    sel_t     rsel;
    sel_t     wsel;
    ctl_cmd_t cmd;
    logic [2:0]  fen;
    logic [31:0] rd_word;
    logic        key_ok;

    assign rsel = decode(addr);
    assign wsel = wr_en ? rsel : '0;

    assign cmd.nmi_set  = wsel.ctlst & wdata[31];
    assign cmd.dsr_set  = wsel.ctlst & wdata[28];
    assign cmd.dsr_clr  = wsel.ctlst & wdata[27];
    assign cmd.tick_set = wsel.ctlst & wdata[26];
    assign cmd.tick_clr = wsel.ctlst & wdata[25];

    assign key_ok = wsel.rstc && (wdata[31:16] == RST_WR_KEY);

    sysexc_sys u_sys (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .fen_we    (wsel.hstat),
        .fen_wd    (wdata[18:16]),
        .raise     (sys_raise),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec),
        .pend      (sys_pend),
        .fen       (fen),
        .en        (sys_en)
    );

    sysexc_ext #(.NIRQ(NIRQ)) u_ext (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .trig_we   (wsel.trig),
        .trig_idx  (wdata[8:0]),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec),
        .pend      (ext_pend)
    );

    sysexc_rdmux #(.NIRQ(NIRQ)) u_rd (
        .sel        (rsel),
        .sys_pend   (sys_pend),
        .ext_pend   (ext_pend),
        .fen        (fen),
        .sys_active (sys_active),
        .act_valid  (act_valid),
        .act_vec    (act_vec),
        .nested     (nested),
        .hp_valid   (hp_valid),
        .hp_vec     (hp_vec),
        .vec_base   (vec_base),
        .word       (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_base <= '0;
            rst_req  <= 1'b0;
            vclr_req <= 1'b0;
            rdata    <= '0;
        end else begin
            if (wsel.vbase) vec_base <= wdata & VBASE_MASK;
            rst_req  <= key_ok & wdata[2];
            vclr_req <= key_ok & wdata[1];
            if (rd_en) rdata <= rd_word;
        end
    end

endmodule

// File: rtl/sysexc_regs_chk.sv
module sysexc_regs_chk #(
    parameter int NIRQ = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [11:0]     addr,
    input logic [31:0]     wdata,
    input logic [15:0]     sys_raise,
    input logic            ack_valid,
    input logic [8:0]      ack_vec,
    input logic [15:0]     sys_pend,
    input logic [NIRQ-1:0] ext_pend,
    input logic [31:0]     vec_base,
    input logic            rst_req,
    input logic            vclr_req
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    after_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (sys_pend == '0 && ext_pend == '0 && vec_base == '0));

    // R2
    dsr_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 12'hD04 && wdata[28]) |=> sys_pend[14]);

    // R6
    rst_req_keyed_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(wr_en && addr == 12'hD0C && wdata[31:16] == 16'h05FA));

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req || vclr_req) |=> !$past(wr_en) || $past(addr) == 12'hD0C || (!rst_req && !vclr_req));

    // R10
    nmi_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_vec == 9'd2 && !sys_raise[2] &&
         !(wr_en && addr == 12'hD04 && wdata[31])) |=> !sys_pend[2]);

    // R5
    vbase_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        vec_base[6:0] == 7'd0);

endmodule

bind sysexc_regs sysexc_regs_chk #(.NIRQ(NIRQ)) u_chk (.*);

// File: tb/sysexc_regs_tb.sv
module sysexc_regs_tb;

    localparam int NIRQ = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en, rd_en;
    logic [11:0]     addr;
    logic [31:0]     wdata;
    logic [31:0]     rdata;
    logic [NIRQ-1:0] irq_in;
    logic [15:0]     sys_raise;
    logic            ack_valid;
    logic [8:0]      ack_vec;
    logic            act_valid;
    logic [8:0]      act_vec;
    logic            nested;
    logic [15:0]     sys_active;
    logic            hp_valid;
    logic [8:0]      hp_vec;
    logic [15:0]     sys_pend;
    logic [NIRQ-1:0] ext_pend;
    logic [15:0]     sys_en;
    logic [31:0]     vec_base;
    logic            rst_req, vclr_req;

    always #10 clk = ~clk;

    sysexc_regs #(.NIRQ(NIRQ)) u_dut (.*);

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];
    int n_chk = 0;
    int n_err = 0;
    logic rd_seen = 1'b0;
    bit   done = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: compares registered read data against the queue
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("R12 unexpected read", 64'(rdata), 64'hDEAD);
            else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(it.tag, 64'(rdata), 64'(it.exp));
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back('{exp: e, tag: tag});
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        irq_in = '0; sys_raise = '0; ack_valid = 0; ack_vec = '0;
        act_valid = 0; act_vec = '0; nested = 0; sys_active = '0;
        hp_valid = 0; hp_vec = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 sys_pend", 64'(sys_pend), 64'h0);
        check("R1 ext_pend", 64'(ext_pend), 64'h0);
        check("R1 sys_en", 64'(sys_en), 64'hD804);
        check("R1 vec_base", 64'(vec_base), 64'h0);
        check("R1 rdata", 64'(rdata), 64'h0);

        // R2 set NMI, deferred service, tick
        wr(12'hD04, 32'h9400_0000);
        check("R2 set three", 64'(sys_pend), 64'hC004);
        // R3 packed read, nothing active, nothing pending externally
        rd(12'hD04, 32'h9400_0800, "R3 ctl word idle");
        // R2 set and clear together: set wins
        wr(12'hD04, 32'h1800_0000);
        check("R2 set wins", 64'(sys_pend[14]), 64'h1);
        wr(12'hD04, 32'h0A00_0000);
        check("R2 clears", 64'(sys_pend), 64'h0004);

        // R7 trigger writes
        wr(12'hF00, 32'h0000_0005);
        check("R7 idx5", 64'(ext_pend), 64'h20);
        wr(12'hF00, 32'h0000_0240);
        check("R7 idx64 ignored", 64'(ext_pend), 64'h20);
        wr(12'hF00, 32'hABCD_E03F);
        check("R7 idx63", 64'(ext_pend), 64'h8000_0000_0000_0020);
        wr(12'hF00, 32'h0000_01FF);
        check("R7 idx511 ignored", 64'(ext_pend), 64'h8000_0000_0000_0020);

        // R3 packed read with active, nested and pending vectors
        act_valid = 1; act_vec = 9'h13; nested = 1; hp_valid = 1; hp_vec = 9'h25;
        rd(12'hD04, 32'h8042_5013, "R3 ctl word busy");
        act_valid = 0; nested = 0; hp_valid = 0;

        // R8
        rd(12'h004, 32'h1, "R8 line count");

        // R5
        wr(12'hD08, 32'h2000_01FF);
        check("R5 vec_base", 64'(vec_base), 64'h2000_0180);
        rd(12'hD08, 32'h2000_0180, "R5 read back");

        // R6 keyed writes
        wr(12'hD0C, 32'h05FA_0004);
        check("R6 rst_req", 64'({rst_req, vclr_req}), 64'h2);
        @(negedge clk);
        check("R6 pulse ends", 64'({rst_req, vclr_req}), 64'h0);
        wr(12'hD0C, 32'h1234_0006);
        check("R6 no key", 64'({rst_req, vclr_req}), 64'h0);
        wr(12'hD0C, 32'h05FA_0002);
        check("R6 vclr_req", 64'({rst_req, vclr_req}), 64'h1);
        rd(12'hD0C, 32'hFA05_0000, "R6 read");

        // R4 handler status
        wr(12'hD24, 32'h0007_0000);
        check("R4 sys_en", 64'(sys_en), 64'hD874);
        sys_raise = 16'h0870;
        @(negedge clk);
        sys_raise = '0;
        sys_active = 16'hFFFF;
        rd(12'hD24, 32'h0007_FD8B, "R4 status word");
        sys_active = '0;
        wr(12'hD24, 32'h0002_0000);
        check("R4 enable subset", 64'(sys_en), 64'hD824);

        // R9 edge on line 3
        irq_in[3] = 1'b1;
        @(negedge clk);
        check("R9 edge sets", 64'(ext_pend[3]), 64'h1);
        ack_valid = 1; ack_vec = 9'd19;
        @(negedge clk);
        ack_valid = 0;
        @(negedge clk);
        check("R9 level no reset", 64'(ext_pend[3]), 64'h0);
        // R10 edge and acknowledge in the same cycle
        irq_in[3] = 1'b0;
        @(negedge clk);
        irq_in[3] = 1'b1; ack_valid = 1; ack_vec = 9'd19;
        @(negedge clk);
        ack_valid = 0;
        check("R10 edge beats ack", 64'(ext_pend[3]), 64'h1);
        // R10 NMI write and acknowledge in the same cycle, then ack alone
        addr = 12'hD04; wdata = 32'h8000_0000; wr_en = 1; ack_valid = 1; ack_vec = 9'd2;
        @(negedge clk);
        wr_en = 0;
        check("R10 set beats ack", 64'(sys_pend[2]), 64'h1);
        @(negedge clk);
        ack_valid = 0;
        check("R10 ack clears", 64'(sys_pend[2]), 64'h0);

        // R11 unmapped
        begin
            logic [15:0] sp;
            logic [NIRQ-1:0] ep;
            sp = sys_pend; ep = ext_pend;
            wr(12'hD10, 32'hFFFF_FFFF);
            wr(12'h100, 32'hFFFF_FFFF);
            check("R11 sys_pend kept", 64'(sys_pend), 64'(sp));
            check("R11 ext_pend kept", 64'(ext_pend), 64'(ep));
            check("R11 vec_base kept", 64'(vec_base), 64'h2000_0180);
            check("R11 sys_en kept", 64'(sys_en), 64'hD824);
            rd(12'hD10, 32'h0, "R11 read zero");
        end

        // R12 rdata holds without rd_en
        addr = 12'h004;
        repeat (2) @(negedge clk);
        check("R12 hold", 64'(rdata), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule